// File: doc/BRIEF.md
# ADC engine register block

This block is the register file of one analog-to-digital engine, reached over a simple 32-bit register bus. The bus also allows 16-bit reads of the packed sample words. The file holds a control word, an interrupt flag word, detect and clock control words, a set of packed data words (two 10-bit channel samples per word), one window-bounds word per channel and one hysteresis word per channel, plus an interrupt source mask and a small trim field. Write masks are applied as each word is stored, so a readback shows only the fields that exist.

No converter stands behind the data words. Each read of an active data word returns the stored pair and then moves both samples forward by fixed steps, which works as a synthetic sample generator. The new pair is then checked against the two channels' windows. A sample outside its window sets a sticky flag for that pair, and the interrupt output stays high while any pair flag is set. Software clears flags by writing the interrupt flag word.

A parameter selects 16 or 8 channels. With 8 channels, the data, bounds and hysteresis words for channels 8 to 15 are inactive.

Top module: `adc_engine_regs`

## Requirements
- R1: After reset, the detect control word (0x08) and the clock control word (0x0C) read 0x0000000F. Every other register, including control (0x00), interrupt flags (0x04) and all bounds words, reads 0, and `irq` is low.
- R2: Writes to a data word (0x10 + 4p) or a bounds word (0x30 + 4c) keep only bits 9:0 and 25:16. All other bits are stored as 0.
- R3: Writes to a hysteresis word (0x70 + 4c) keep bit 31 and the two fields at bits 9:0 and 25:16. All other bits are stored as 0.
- R4: On a write to control (0x00), stored bit 8 equals written bit 0, and stored bit 5 is always 0. The other bits are stored as written.
- R5: Interrupt source (0xC0) keeps written bits 15:0, and trim (0xC4) keeps written bits 3:0. Interrupt flags (0x04), detect control (0x08) and clock control (0x0C) keep all 32 written bits.
- R6: A full-width read of an active data word returns its value before the read. After the read, the lower sample (bits 9:0) grows by 5 and the upper sample (bits 25:16) grows by 7. Both wrap modulo 1024, and bits 31:26 stay 0.
- R7: After a read of data pair p, the new lower sample is compared with the window in bounds word 2p, and the new upper sample with the window in bounds word 2p+1. In each bounds word, bits 9:0 hold the minimum and bits 25:16 hold the maximum. A sample below the minimum or above the maximum sets bit p of the interrupt flag word. The bit stays set until software writes the flag word, and `irq` is high while any pair bit is set.
- R8: A sample equal to its minimum or its maximum is not a violation. A read whose new pair is inside both windows changes no interrupt flag.
- R9: A 16-bit read (`bus_half`=1) at a data address with address bit 1 set returns sample bits 31:16 in `bus_rdata` bits 15:0, with bits 31:16 of `bus_rdata` at 0. The read still advances the pair as in R6.
- R10: Reads of unmapped offsets return 0, and so do reads of offsets with address bit 0 set. Writes to such offsets change no register.
- R11: With 8 channels, data words for pairs 4 to 7 (0x20 to 0x2C), bounds words 8 to 15 (0x50 to 0x6C) and hysteresis words 8 to 15 (0x90 to 0xAC) read 0. Writes to them are dropped, and a read of them sets no interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 16-bit read; with address bit 1 set on a data word, returns the upper half |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address during a read |
| irq | output | 1 | High while any pair bit of the interrupt flag word is set |

## Verification
A single data read both returns the old pair and, at the same clock edge, stores the advanced pair and runs the window compare on it. The stored pairs are therefore set so that the advance wraps past 1023, or lands exactly on a minimum or maximum, or goes one step over a maximum or under a minimum. Each case is judged by the returned value, the next read of the same word, and the interrupt flag word read back over the bus.

A flag that is already set meets a later read that is in range. The test then checks that the flag stays set and that only a flag-word write clears `irq`.

// File: rtl/adc_engine_regs.sv
module adc_engine_regs #(
  parameter int NUM_CH  = 16,
  parameter int SW      = 10,
  parameter int STEP_LO = 5,
  parameter int STEP_HI = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_wr,
  input  logic        bus_half,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int NP = NUM_CH / 2;
  localparam int PW = $clog2(NP);
  localparam int CW = $clog2(NUM_CH);
  localparam logic [5:0] NP6 = 6'(NP);
  localparam logic [5:0] NC6 = 6'(NUM_CH);
  localparam logic [31:0] SMASK = 32'((1 << SW) - 1);
  localparam logic [31:0] FMASK = SMASK | (SMASK << 16);
  localparam logic [31:0] HMASK = FMASK | 32'h8000_0000;

  logic [31:0] ctrl_q, intf_q, det_q, clkc_q, isrc_q, trim_q;
  logic [31:0] data_q [NP];
  logic [31:0] bnd_q  [NUM_CH];
  logic [31:0] hys_q  [NUM_CH];

  logic [5:0] word, poff, boff, hoff;
  logic       aligned;
  assign word    = bus_addr[7:2];
  assign aligned = ~bus_addr[0];
  assign poff    = word - 6'd4;
  assign boff    = word - 6'd12;
  assign hoff    = word - 6'd28;

  logic is_ctrl, is_intf, is_det, is_clk, is_isrc, is_trim;
  logic data_act, bnd_act, hys_act, hit;
  assign is_ctrl  = aligned && word == 6'd0;
  assign is_intf  = aligned && word == 6'd1;
  assign is_det   = aligned && word == 6'd2;
  assign is_clk   = aligned && word == 6'd3;
  assign is_isrc  = aligned && word == 6'd48;
  assign is_trim  = aligned && word == 6'd49;
  assign data_act = aligned && poff < NP6;
  assign bnd_act  = aligned && boff < NC6;
  assign hys_act  = aligned && hoff < NC6;
  assign hit = is_ctrl | is_intf | is_det | is_clk | is_isrc | is_trim
             | data_act | bnd_act | hys_act;

  logic [PW-1:0] pidx;
  logic [CW-1:0] bidx, hidx;
  assign pidx = poff[PW-1:0];
  assign bidx = boff[CW-1:0];
  assign hidx = hoff[CW-1:0];

  logic rd_data, wr_any;
  assign rd_data = bus_en && !bus_wr && data_act;
  assign wr_any  = bus_en && bus_wr;

  logic [31:0] cur, blo, bhi;
  logic [SW-1:0] lo_new, hi_new;
  logic viol;
  assign cur    = data_q[pidx];
  assign blo    = bnd_q[{pidx, 1'b0}];
  assign bhi    = bnd_q[{pidx, 1'b1}];
  assign lo_new = cur[SW-1:0] + SW'(STEP_LO);
  assign hi_new = cur[16 +: SW] + SW'(STEP_HI);
  assign viol   = lo_new < blo[SW-1:0] || lo_new > blo[16 +: SW]
               || hi_new < bhi[SW-1:0] || hi_new > bhi[16 +: SW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      intf_q <= '0;
      det_q  <= 32'hF;
      clkc_q <= 32'hF;
      isrc_q <= '0;
      trim_q <= '0;
      for (int i = 0; i < NP; i++) data_q[i] <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        bnd_q[i] <= '0;
        hys_q[i] <= '0;
      end
    end else if (wr_any) begin
      if (is_ctrl)  ctrl_q <= {bus_wdata[31:9], bus_wdata[0], bus_wdata[7:6], 1'b0, bus_wdata[4:0]};
      if (is_intf)  intf_q <= bus_wdata;
      if (is_det)   det_q  <= bus_wdata;
      if (is_clk)   clkc_q <= bus_wdata;
      if (is_isrc)  isrc_q <= bus_wdata & 32'hFFFF;
      if (is_trim)  trim_q <= bus_wdata & 32'hF;
      if (data_act) data_q[pidx] <= bus_wdata & FMASK;
      if (bnd_act)  bnd_q[bidx]  <= bus_wdata & FMASK;
      if (hys_act)  hys_q[hidx]  <= bus_wdata & HMASK;
    end else if (rd_data) begin
      data_q[pidx] <= (32'(hi_new) << 16) | 32'(lo_new);
      if (viol) intf_q[pidx] <= 1'b1;
    end
  end

  logic [31:0] raw;
  always_comb begin
    raw = '0;
    if (is_ctrl)  raw = ctrl_q;
    if (is_intf)  raw = intf_q;
    if (is_det)   raw = det_q;
    if (is_clk)   raw = clkc_q;
    if (is_isrc)  raw = isrc_q;
    if (is_trim)  raw = trim_q;
    if (data_act) raw = cur;
    if (bnd_act)  raw = bnd_q[bidx];
    if (hys_act)  raw = hys_q[hidx];
  end

  assign bus_rdata = (data_act && bus_half && bus_addr[1]) ? {16'h0, raw[31:16]} : raw;
  assign irq = |intf_q[NP-1:0];

  // R6: the stored pair advances by the fixed step after a full read
  a_r6_sample_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !bus_half) |=> data_q[$past(pidx)][SW-1:0] == SW'($past(bus_rdata[SW-1:0]) + STEP_LO));

  // R4: init bit mirrors enable, auto-compensate never stored
  a_r4_init_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && is_ctrl) |=> (ctrl_q[8] == $past(bus_wdata[0])) && !ctrl_q[5]);

  // R7: flags only drop through a write of the flag word
  a_r7_sticky_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_any && is_intf) |-> (($past(intf_q) & ~intf_q) == 32'h0));

  // R7: irq rises only after a data read or a flag-word write
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(rd_data || (wr_any && is_intf)));

  // R10: unmapped or misaligned reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr && !hit) |-> bus_rdata == 32'h0);
endmodule

// File: tb/adc_engine_regs_tb.sv
`timescale 1ns/1ps
module adc_engine_regs_tb;
  logic clk = 0, rst_n = 0;
  logic en16 = 0, en8 = 0, wr = 0, half = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rd16, rd8;
  logic irq16, irq8;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  adc_engine_regs u_dut (.clk(clk), .rst_n(rst_n), .bus_en(en16), .bus_wr(wr),
    .bus_half(half), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd16), .irq(irq16));
  adc_engine_regs #(.NUM_CH(8)) u_dut8 (.clk(clk), .rst_n(rst_n), .bus_en(en8), .bus_wr(wr),
    .bus_half(half), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd8), .irq(irq8));

  // {addr, wdata, expected readback, requirement number}
  localparam logic [79:0] VEC [10] = '{
    {8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFDF, 8'd4},  // R4
    {8'h00, 32'h0000_0130, 32'h0000_0010, 8'd4},  // R4
    {8'h00, 32'h0000_0001, 32'h0000_0101, 8'd4},  // R4
    {8'h30, 32'hFFFF_FFFF, 32'h03FF_03FF, 8'd2},  // R2
    {8'h14, 32'hFFFF_FFFF, 32'h03FF_03FF, 8'd2},  // R2
    {8'h7C, 32'hFFFF_FFFF, 32'h83FF_03FF, 8'd3},  // R3
    {8'hC0, 32'hFFFF_FFFF, 32'h0000_FFFF, 8'd5},  // R5
    {8'hC4, 32'hFFFF_FFFF, 32'h0000_000F, 8'd5},  // R5
    {8'h08, 32'h1234_5678, 32'h1234_5678, 8'd5},  // R5
    {8'hB0, 32'hFFFF_FFFF, 32'h0000_0000, 8'd10}  // R10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrt(input bit d8, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1; half = 0;
    if (d8) en8 = 1; else en16 = 1;
    @(negedge clk);
    en8 = 0; en16 = 0; wr = 0;
  endtask

  task automatic rd(input bit d8, input logic [7:0] a, input bit h, output logic [31:0] v);
    @(negedge clk);
    addr = a; wr = 0; half = h;
    if (d8) en8 = 1; else en16 = 1;
    #1 v = d8 ? rd8 : rd16;
    @(negedge clk);
    en8 = 0; en16 = 0; half = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1 reset state
    rd(0, 8'h08, 0, v); chk("R1 detect", v, 32'hF);
    rd(0, 8'h0C, 0, v); chk("R1 clock", v, 32'hF);
    rd(0, 8'h00, 0, v); chk("R1 control", v, 0);
    rd(0, 8'h04, 0, v); chk("R1 flags", v, 0);
    rd(0, 8'h6C, 0, v); chk("R1 bounds15", v, 0);
    chk("R1 irq", {31'b0, irq16}, 0);

    for (int i = 0; i < 10; i++) begin
      wrt(0, VEC[i][79:72], VEC[i][71:40]);
      rd(0, VEC[i][79:72], 0, v);
      chk($sformatf("R%0d vector %0d", VEC[i][7:0], i), v, VEC[i][39:8]);
    end

    do_reset();
    rd(0, 8'h30, 0, v); chk("R1 bounds0 after reset", v, 0);
    wrt(0, 8'h30, 32'h03FF_0000);
    wrt(0, 8'h34, 32'h03FF_0000);
    wrt(0, 8'h10, 32'h03FE_03FC);
    rd(0, 8'h10, 0, v); chk("R6 old value returned", v, 32'h03FE_03FC);
    rd(0, 8'h10, 0, v); chk("R6 wrap modulo 1024", v, 32'h0005_0001);
    rd(0, 8'h04, 0, v); chk("R8 no flag in range", v, 0);
    chk("R8 irq low", {31'b0, irq16}, 0);

    wrt(0, 8'h38, 32'h03FF_000A);
    wrt(0, 8'h3C, 32'h00C8_0064);
    wrt(0, 8'h14, 32'h00C1_0005);
    rd(0, 8'h14, 0, v);
    rd(0, 8'h04, 0, v); chk("R8 samples on min and max", v, 0);
    rd(0, 8'h14, 0, v); chk("R6 pair at limits", v, 32'h00C8_000A);
    rd(0, 8'h04, 0, v); chk("R7 upper above max sets bit1", v, 32'h2);
    chk("R7 irq high", {31'b0, irq16}, 1);
    wrt(0, 8'h04, 32'h0);
    chk("R7 flag write clears irq", {31'b0, irq16}, 0);
    wrt(0, 8'h14, 32'h0064_0000);
    rd(0, 8'h14, 0, v);
    rd(0, 8'h04, 0, v); chk("R7 lower below min sets bit1", v, 32'h2);
    wrt(0, 8'h14, 32'h0064_0005);
    rd(0, 8'h14, 0, v);
    rd(0, 8'h04, 0, v); chk("R7 flag sticky", v, 32'h2);
    chk("R7 irq stays", {31'b0, irq16}, 1);

    wrt(0, 8'h10, 32'h0155_00AA);
    rd(0, 8'h12, 1, v); chk("R9 upper half read", v, 32'h0000_0155);
    rd(0, 8'h10, 0, v); chk("R9 half read advanced pair", v, 32'h015C_00AF);

    wrt(0, 8'hFC, 32'hFFFF_FFFF);
    rd(0, 8'hFC, 0, v); chk("R10 unmapped read", v, 0);
    wrt(0, 8'h01, 32'hFFFF_FFFF);
    rd(0, 8'h01, 0, v); chk("R10 misaligned read", v, 0);
    rd(0, 8'h00, 0, v); chk("R10 control untouched", v, 0);

    wrt(1, 8'h4C, 32'h0011_0022);
    rd(1, 8'h4C, 0, v); chk("R11 bounds7 active", v, 32'h0011_0022);
    wrt(1, 8'h50, 32'hFFFF_FFFF);
    rd(1, 8'h50, 0, v); chk("R11 bounds8 inactive", v, 0);
    wrt(1, 8'h90, 32'hFFFF_FFFF);
    rd(1, 8'h90, 0, v); chk("R11 hyst8 inactive", v, 0);
    wrt(1, 8'h20, 32'h0000_0123);
    rd(1, 8'h20, 0, v); chk("R11 data pair4 inactive", v, 0);
    rd(1, 8'h04, 0, v); chk("R11 no flag from inactive pair", v, 0);
    wrt(1, 8'h1C, 32'h0000_0123);
    rd(1, 8'h1C, 0, v); chk("R11 data pair3 active", v, 32'h0000_0123);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule